// File: doc/BRIEF.md
# Sixteen-Pin General-Purpose I/O Port

This block is one general-purpose I/O port behind a small register bus. Software gives every pin its own direction, reads the pin levels back through a two-stage synchronizer, and drives output levels from a data register. Output pins are driven through `pin_out` qualified by `pin_oe`. The pad ring, or the testbench's tri-state nets, merges these with external drivers and returns the resolved levels on `pin_in`.

A write-only bit-change register lets software raise or drop any subset of output bits in one bus write, without a read-modify-write. The mode register and the output data register accept byte-lane enables, so one byte can be updated without touching its neighbours.

The bus has four word registers, selected by byte-address bits [3:2]: 0 is the pin mode register, 1 is the sampled-level register (read-only), 2 is the output data register, and 3 is the bit-change register. A read request returns its data one cycle later.

Top module: `gpio_port`

## Requirements
- R1: While reset is asserted, and right after it, every pin is an input (`pin_oe` all zero), `pin_out` is zero, and the mode and output data registers read back as zero.
- R2: Pin i takes its direction from mode bits [2i+1:2i]. Code 01 makes it an output (`pin_oe[i]`=1). Codes 00, 10 and 11 make it an input. Each pin is independent of the others.
- R3: `pin_out` always equals the output data register, and it changes only on a bus write. Pins whose mode is output present that value on the external net.
- R4: The sampled-level register returns the pin levels through two flops. Suppose a pin changes before clock edge k. A read accepted at edge k or k+1 returns the old level, and a read accepted at edge k+2 or later returns the new level.
- R5: Writes to the output data register obey byte enables. `bus_be[0]` guards pins 7..0 and `bus_be[1]` guards pins 15..8. A disabled lane keeps its bits.
- R6: Bits 15..0 of a bit-change write (lanes 0 and 1) set the matching output bit where they are 1. Where they are 0, they leave the bit unchanged.
- R7: Bit 16+i of a bit-change write (lanes 2 and 3) clears output bit i where it is 1.
- R8: If a single bit-change write both sets and clears the same bit, the bit ends at 1.
- R9: The bit-change register always reads as zero. Writes to the sampled-level register change nothing.
- R10: `bus_rvalid` is high exactly one cycle after each accepted read, and never otherwise.
- R11: Writes to the mode register obey the four byte enables. Each lane covers four pins' fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address, bits [3:2] pick the register |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| pin_in | input | NPINS | Resolved pin levels from the pads |
| pin_out | output | NPINS | Output drive values |
| pin_oe | output | NPINS | Output enables, one per pin |

## Verification
The bench builds the port with its default of 16 pins. At that width the mode register fills all 32 data bits, and both byte lanes of the output register map to real pins. Every lane-enable combination, and both halves of the bit-change word, therefore reach live state. At 16 pins, random mode words hit all four direction codes on many pins at once. The nets mix driving and listening pins, so the level read-back shows both the port's own drive and the external drivers.

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int NPINS = 16,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  input  logic [3:0]       bus_be,
  output logic [31:0]      bus_rdata,
  output logic             bus_rvalid,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe
);
  localparam int MW = 2 * NPINS;
  localparam logic [1:0] SEL_MODE = 2'd0, SEL_LVL = 2'd1, SEL_DRV = 2'd2, SEL_CHG = 2'd3;

  logic [MW-1:0]    mode_q;
  logic [NPINS-1:0] drv_q, smp1_q, smp2_q;
  logic [31:0]      lane, rd_mux;
  logic [1:0]       sel;
  logic             wr, rd;

  assign sel  = bus_addr[3:2];
  assign wr   = bus_valid && bus_write;
  assign rd   = bus_valid && !bus_write;
  assign lane = {{8{bus_be[3]}}, {8{bus_be[2]}}, {8{bus_be[1]}}, {8{bus_be[0]}}};

  logic [NPINS-1:0] set_v, clr_v, drv_m;
  logic [MW-1:0]    mode_m;
  assign set_v  = bus_wdata[NPINS-1:0] & lane[NPINS-1:0];
  assign clr_v  = bus_wdata[16 +: NPINS] & lane[16 +: NPINS];
  assign drv_m  = lane[NPINS-1:0];
  assign mode_m = lane[MW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      drv_q  <= '0;
    end else if (wr) begin
      case (sel)
        SEL_MODE: mode_q <= (mode_q & ~mode_m) | (bus_wdata[MW-1:0] & mode_m);
        SEL_DRV:  drv_q  <= (drv_q & ~drv_m) | (bus_wdata[NPINS-1:0] & drv_m);
        SEL_CHG:  drv_q  <= (drv_q & ~clr_v) | set_v;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp1_q <= '0;
      smp2_q <= '0;
    end else begin
      smp1_q <= pin_in;
      smp2_q <= smp1_q;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_MODE: rd_mux[MW-1:0]    = mode_q;
      SEL_LVL:  rd_mux[NPINS-1:0] = smp2_q;
      SEL_DRV:  rd_mux[NPINS-1:0] = drv_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd;
      if (rd) bus_rdata <= rd_mux;
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_dir
    assign pin_oe[i] = (mode_q[2*i +: 2] == 2'b01);
  end

  assign pin_out = drv_q;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int NPINS = 16,
  parameter int AW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_valid,
  input logic             bus_write,
  input logic [AW-1:0]    bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [3:0]       bus_be,
  input logic [31:0]      bus_rdata,
  input logic             bus_rvalid,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] pin_oe
);
  function automatic logic [NPINS-1:0] dir_of(logic [31:0] m);
    logic [NPINS-1:0] r;
    for (int i = 0; i < NPINS; i++) r[i] = (m[2*i +: 2] == 2'b01);
    return r;
  endfunction

  logic [31:0]      lm;
  logic [NPINS-1:0] s_c, c_c;
  assign lm  = {{8{bus_be[3]}}, {8{bus_be[2]}}, {8{bus_be[1]}}, {8{bus_be[0]}}};
  assign s_c = bus_wdata[NPINS-1:0] & lm[NPINS-1:0];
  assign c_c = bus_wdata[16 +: NPINS] & lm[16 +: NPINS];

  always @(negedge clk)
    if (!rst_n) assert_reset_idle_R1: assert (pin_oe == '0 && pin_out == '0);

  assert_full_mode_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_write && bus_addr[3:2] == 2'd0 && bus_be == 4'hF
    |=> pin_oe == dir_of($past(bus_wdata)));

  assert_quiet_outputs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_write) |=> $stable(pin_out) && $stable(pin_oe));

  assert_lane_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_write && bus_addr[3:2] == 2'd2
    |=> ((pin_out ^ $past(pin_out)) & ~$past(lm[NPINS-1:0])) == '0);

  assert_set_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_write && bus_addr[3:2] == 2'd3
    |=> pin_out == (($past(pin_out) & ~$past(c_c)) | $past(s_c)));

  assert_change_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_write && bus_addr[3:2] == 2'd3 |=> bus_rdata == '0);

  assert_rvalid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> bus_rvalid);

  assert_no_spurious_rvalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !bus_rvalid);
endmodule

bind gpio_port gpio_port_chk #(.NPINS(NPINS), .AW(AW)) u_gpio_port_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
  .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/test_gpio_port.sv
`timescale 1ns/1ps
module test_gpio_port;
  localparam int N = 16;
  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0;
  logic [3:0] bus_addr = 0, bus_be = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic bus_rvalid;
  logic [N-1:0] pin_out, pin_oe, ext_val = 0;
  tri   [N-1:0] pad;
  logic [N-1:0] pin_in;

  for (genvar i = 0; i < N; i++) begin : g_pad
    assign pad[i] = pin_oe[i] ? pin_out[i] : 1'bz;
    assign pad[i] = pin_oe[i] ? 1'bz : ext_val[i];
  end
  assign pin_in = pad;

  gpio_port #(.NPINS(N), .AW(4)) i_gpio_port (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe));

  always #5 clk = ~clk;

  int tests = 0, fails = 0;
  logic [31:0] m_mode = 0;
  logic [N-1:0] m_drv = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] lanes(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic logic [N-1:0] dir_exp(input logic [31:0] m);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = (m[2*i +: 2] == 2'b01);
    return r;
  endfunction

  function automatic logic [N-1:0] pads_exp();
    logic [N-1:0] oe;
    oe = dir_exp(m_mode);
    return (oe & m_drv) | (~oe & ext_val);
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
    logic [31:0] l;
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
    l = lanes(be);
    case (a[3:2])
      2'd0: m_mode = (m_mode & ~l) | (d & l);
      2'd2: m_drv = (m_drv & ~l[N-1:0]) | (d[N-1:0] & l[N-1:0]);
      2'd3: m_drv = (m_drv & ~(d[31:16] & l[31:16])) | (d[N-1:0] & l[N-1:0]);
      default: ;
    endcase
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d, output logic v);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
    d = bus_rdata; v = bus_rvalid;
    @(negedge clk);
    chk(bus_rvalid == 0, "R10 rvalid drops", {31'd0, bus_rvalid}, 0);
  endtask

  task automatic pins_ok(input string tag);
    chk(pin_oe == dir_exp(m_mode), {tag, " R2 pin_oe"}, pin_oe, dir_exp(m_mode));
    chk(pin_out == m_drv, {tag, " R3 pin_out"}, pin_out, m_drv);
    chk(pad == pads_exp(), {tag, " R3 pad"}, pad, pads_exp());
  endtask

  bit done = 0;
  initial begin
    #(200000 * 10);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, dd, ex;
    logic v;
    void'($urandom(32'h5eed_61a0));
    repeat (2) @(negedge clk);
    // R1 reset state
    chk(pin_oe == 0 && pin_out == 0, "R1 during reset", {pin_oe, pin_out}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(pin_oe == 0 && pin_out == 0, "R1 after reset", {pin_oe, pin_out}, 0);
    rd(4'h0, d, v); chk(d == 0, "R1 mode reads zero", d, 0);
    rd(4'h8, d, v); chk(d == 0, "R1 drive reads zero", d, 0);
    chk(v == 1, "R10 rvalid one cycle after read", {31'd0, v}, 1);

    // R2 all four codes, mixed
    wr(4'h0, 32'hE4E4_E4E4, 4'hF); pins_ok("codes");
    wr(4'h0, 32'h5555_5555, 4'hF); pins_ok("all out");

    // R5 byte lanes on output register
    wr(4'h8, 32'h0000_A5A5, 4'h3); pins_ok("R5 both lanes");
    wr(4'h8, 32'h0000_3C3C, 4'h1);
    chk(pin_out == 16'hA53C, "R5 low lane only", pin_out, 16'hA53C);
    wr(4'h8, 32'h0000_0F0F, 4'h2);
    chk(pin_out == 16'h0F3C, "R5 high lane only", pin_out, 16'h0F3C);

    // R6 / R7 / R8
    wr(4'hC, 32'h0000_00C0, 4'h3);
    chk(pin_out == 16'h0FFC, "R6 set, zeros untouched", pin_out, 16'h0FFC);
    wr(4'hC, 32'h0F00_0000, 4'hC);
    chk(pin_out == 16'h00FC, "R7 clear", pin_out, 16'h00FC);
    wr(4'hC, 32'h8001_8001, 4'hF);
    chk(pin_out == 16'h80FD, "R8 set beats clear", pin_out, 16'h80FD);

    // R9
    rd(4'hC, d, v); chk(d == 0, "R9 bit-change reads zero", d, 0);
    wr(4'h4, 32'hFFFF_FFFF, 4'hF); pins_ok("R9 level write ignored");
    rd(4'h8, d, v); chk(d[N-1:0] == m_drv, "R9 drive kept", d, m_drv);

    // R11 mode byte lanes
    wr(4'h0, 32'h0000_0000, 4'h4); pins_ok("R11 lane2");
    rd(4'h0, d, v); chk(d == 32'h5500_5555, "R11 mode lanes", d, 32'h5500_5555);

    // R4 synchronizer latency, all pins input
    wr(4'h0, 32'h0, 4'hF);
    ext_val = 16'h1234; @(negedge clk); @(negedge clk);
    ext_val = 16'hBEEF;
    bus_valid = 1; bus_write = 0; bus_addr = 4'h4;
    @(negedge clk); d = bus_rdata;
    @(negedge clk); dd = bus_rdata;
    @(negedge clk); ex = bus_rdata; bus_valid = 0;
    chk(d == 32'h1234, "R4 read at edge k old", d, 32'h1234);
    chk(dd == 32'h1234, "R4 read at edge k+1 old", dd, 32'h1234);
    chk(ex == 32'hBEEF, "R4 read at edge k+2 new", ex, 32'hBEEF);
    @(negedge clk);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      logic [3:0] be;
      op = $urandom_range(0, 5);
      be = 4'($urandom);
      ext_val = N'($urandom);
      case (op)
        0: wr(4'h0, $urandom, be);
        1: wr(4'h8, $urandom, be);
        2: wr(4'hC, $urandom, be);
        3: wr(4'h4, $urandom, be);
        4: begin
             repeat (2) @(negedge clk);
             rd(4'h4, d, v);
             chk(d == {16'd0, pads_exp()}, "R4 random level", d, {16'd0, pads_exp()});
           end
        default: begin
             rd(4'h0, d, v); chk(d == m_mode, "R11 random mode readback", d, m_mode);
             rd(4'h8, d, v); chk(d == {16'd0, m_drv}, "R3 random drive readback", d, {16'd0, m_drv});
           end
      endcase
      pins_ok("random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule